// File: doc/BRIEF.md
# Converter Self-Calibration Sequencer

This block is the digital controller for the foreground self-calibration of a successive-approximation converter. Software writes a start bit to launch a run. The block then drives a 7-bit trim code to the analog side and samples a comparator once per bit, from the most significant bit down, to find a signed correction factor. It keeps that factor and subtracts it from every raw 12-bit conversion result, saturating into the legal output range.

The start bit reads back as 1 while the search runs, and hardware clears it when the factor is loaded. While the bit is set, conversion start requests are refused. A second software bit, the calibration-reset bit, returns the stored factor to zero. If it arrives during a run, it aborts that run. Switching the converter off clears the factor, stops any run and restarts the 14-clock settling count. A run is accepted only once that count has completed.

Top module: `adc_cal_seq`

## Requirements
- R1: With the converter enabled and settled, no run active and no reset pending, a start write sets `cal_busy` at the next clock edge. `cal_busy` then stays 1 for exactly 8 cycles (7 search steps and 1 load cycle) and is cleared by hardware.
- R2: The search tries the trim bits MSB first, so `trim_code` equals 7'b1000000 in the first search cycle. `cmp_in`=1 means the trial is too high and the bit is dropped. The loaded factor is `trim_code` minus 64, read as a signed 7-bit value. For a comparator that reports (trim-64) > T, the factor equals T clamped to the range -64..63.
- R3: `cal_done` is 1 for exactly one cycle. That cycle is the first cycle in which `cal_busy` reads 0 after a completed run.
- R4: `conv_go` stays 0 while `cal_busy` or `cal_rst_pend` is 1, whatever `conv_req` does. Otherwise `conv_go` follows `conv_req` while `conv_en` is 1.
- R5: A start write while `conv_en` is 0 is ignored, and `cal_busy` stays 0.
- R6: A start write is accepted only after `conv_en` has been 1 for 14 clock edges. A write sampled at the 14th edge is ignored, and one sampled at the 15th is accepted.
- R7: A reset write sets `cal_rst_pend` at the next edge. One edge later, hardware clears `cal_rst_pend` and `cal_factor` becomes 0.
- R8: A reset pending during a run aborts it: `cal_busy` falls, `cal_factor` becomes 0, and `cal_done` is not raised. The reset also wins over a load in the same cycle. A start write in the same cycle as a reset write is ignored.
- R9: `corr_data` = `raw_data` minus the signed `cal_factor`, saturated to 0..4095. It is registered, so `corr_valid` follows `raw_valid` one edge later.
- R10: Dropping `conv_en` clears `cal_factor` and `cal_busy` at the next edge and restarts the settling count.
- R11: After reset, `cal_busy`, `cal_rst_pend`, `cal_done` and `corr_valid` are 0, and `cal_factor` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_en | input | 1 | Converter powered on |
| cal_start_wr | input | 1 | Software writes 1 to the start bit |
| cal_rst_wr | input | 1 | Software writes 1 to the calibration-reset bit |
| cmp_in | input | 1 | Comparator: trial trim code too high |
| conv_req | input | 1 | Conversion start request |
| raw_valid | input | 1 | Raw conversion result valid |
| raw_data | input | 12 | Raw conversion result |
| cal_busy | output | 1 | Start-bit readback, 1 while calibrating |
| cal_rst_pend | output | 1 | Reset-bit readback |
| cal_done | output | 1 | One-cycle completion pulse |
| trim_code | output | 7 | Trial code presented to the analog side |
| cal_factor | output | 7 | Stored signed correction factor |
| conv_go | output | 1 | Granted conversion start |
| corr_valid | output | 1 | Corrected result valid |
| corr_data | output | 12 | Corrected, saturated result |

## Verification
Two functions can fall in the same cycle. The first is the load of a finished search. The second is the service of a reset bit written during the last search step. The bench times a reset write so that it is sampled on the edge that enters the load cycle. It then judges that no done pulse appears, the busy bit falls, and the factor reads zero, not the search result. A second collision is provoked by writing the start and reset bits together, and the start must then be refused.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_LOAD   = 2'd2
    } cal_state_e;
endpackage

// File: rtl/adc_cal_stab.sv
// Settling counter: counts enabled clocks, saturates at the limit.
module adc_cal_stab #(
    parameter int STAB_CYC = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic ready
);
    localparam int CW = $clog2(STAB_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(STAB_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en)
            cnt_d = '0;
        else if (cnt_q != LIMIT)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready = (cnt_q == LIMIT);
endmodule

// File: rtl/adc_cal_sar_step.sv
// One successive-approximation step: try bit idx, keep it unless too high.
module adc_cal_sar_step #(
    parameter int FW = 7
) (
    input  logic [FW-1:0]         code,
    input  logic [$clog2(FW)-1:0] idx,
    input  logic                  too_high,
    output logic [FW-1:0]         trial,
    output logic [FW-1:0]         next_code
);
    logic [FW-1:0] mask;

    for (genvar i = 0; i < FW; i++) begin : g_mask
        assign mask[i] = (idx == i);
    end

    assign trial     = code | mask;
    assign next_code = too_high ? code : trial;
endmodule

// File: rtl/adc_cal_corr.sv
// Applies the signed factor to raw results with saturation, one register stage.
module adc_cal_corr #(
    parameter int RW = 12,
    parameter int FW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw_valid,
    input  logic [RW-1:0] raw_data,
    input  logic [FW-1:0] factor,
    output logic          corr_valid,
    output logic [RW-1:0] corr_data
);
    localparam int SW = RW + 2;

    typedef struct packed {
        logic          valid;
        logic [RW-1:0] data;
    } corr_t;

    corr_t         c_d, c_q;
    logic [SW-1:0] diff;

    always_comb begin
        diff      = {2'b00, raw_data} - {{(SW-FW){factor[FW-1]}}, factor};
        c_d       = c_q;
        c_d.valid = raw_valid;
        if (raw_valid) begin
            if (diff[SW-1])
                c_d.data = '0;
            else if (diff[RW])
                c_d.data = '1;
            else
                c_d.data = diff[RW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign corr_valid = c_q.valid;
    assign corr_data  = c_q.data;
endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
    import adc_cal_pkg::*;
#(
    parameter int RW       = 12,
    parameter int FW       = 7,
    parameter int STAB_CYC = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_en,
    input  logic          cal_start_wr,
    input  logic          cal_rst_wr,
    input  logic          cmp_in,
    input  logic          conv_req,
    input  logic          raw_valid,
    input  logic [RW-1:0] raw_data,
    output logic          cal_busy,
    output logic          cal_rst_pend,
    output logic          cal_done,
    output logic [FW-1:0] trim_code,
    output logic [FW-1:0] cal_factor,
    output logic          conv_go,
    output logic          corr_valid,
    output logic [RW-1:0] corr_data
);
    localparam int IW = $clog2(FW);
    localparam logic [IW-1:0] TOP_IDX = IW'(FW - 1);

    typedef struct packed {
        cal_state_e    state;
        logic          busy;
        logic          pend;
        logic          done;
        logic [FW-1:0] code;
        logic [IW-1:0] idx;
        logic [FW-1:0] factor;
    } ctl_t;

    ctl_t          s_d, s_q;
    logic          settled;
    logic [FW-1:0] trial, next_code;
    logic          start_ok;

    adc_cal_stab #(.STAB_CYC(STAB_CYC)) u_stab (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (conv_en),
        .ready (settled)
    );

    adc_cal_sar_step #(.FW(FW)) u_step (
        .code      (s_q.code),
        .idx       (s_q.idx),
        .too_high  (cmp_in),
        .trial     (trial),
        .next_code (next_code)
    );

    assign start_ok = cal_start_wr && settled && !cal_rst_wr;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!conv_en) begin
            s_d.state  = ST_IDLE;
            s_d.busy   = 1'b0;
            s_d.pend   = 1'b0;
            s_d.code   = '0;
            s_d.factor = '0;
        end else if (s_q.pend) begin
            s_d.state  = ST_IDLE;
            s_d.busy   = 1'b0;
            s_d.pend   = 1'b0;
            s_d.code   = '0;
            s_d.factor = '0;
        end else begin
            unique case (s_q.state)
                ST_IDLE: begin
                    if (start_ok) begin
                        s_d.state = ST_SEARCH;
                        s_d.busy  = 1'b1;
                        s_d.code  = '0;
                        s_d.idx   = TOP_IDX;
                    end
                end
                ST_SEARCH: begin
                    s_d.code = next_code;
                    if (s_q.idx == '0)
                        s_d.state = ST_LOAD;
                    else
                        s_d.idx = s_q.idx - 1'b1;
                end
                ST_LOAD: begin
                    // offset-binary code to two's complement: flip the MSB
                    s_d.factor = {~s_q.code[FW-1], s_q.code[FW-2:0]};
                    s_d.busy   = 1'b0;
                    s_d.done   = 1'b1;
                    s_d.state  = ST_IDLE;
                end
                default: s_d.state = ST_IDLE;
            endcase
        end
        if (conv_en && cal_rst_wr)
            s_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    adc_cal_corr #(.RW(RW), .FW(FW)) u_corr (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_valid  (raw_valid),
        .raw_data   (raw_data),
        .factor     (s_q.factor),
        .corr_valid (corr_valid),
        .corr_data  (corr_data)
    );

    assign cal_busy     = s_q.busy;
    assign cal_rst_pend = s_q.pend;
    assign cal_done     = s_q.done;
    assign cal_factor   = s_q.factor;
    assign trim_code    = (s_q.state == ST_SEARCH) ? trial : '0;
    assign conv_go      = conv_req && conv_en && !s_q.busy && !s_q.pend;
endmodule

// File: rtl/adc_cal_seq_chk.sv
module adc_cal_seq_chk #(
    parameter int FW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          conv_en,
    input logic          cal_start_wr,
    input logic          cal_rst_wr,
    input logic          cal_busy,
    input logic          cal_rst_pend,
    input logic          cal_done,
    input logic [FW-1:0] cal_factor,
    input logic          conv_go
);
    assert_no_conv_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy || cal_rst_pend) |-> !conv_go);

    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> !cal_done);

    assert_done_ends_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_done) |-> (!cal_busy && $past(cal_busy)));

    assert_pend_self_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_rst_pend && !cal_rst_wr) |=> (!cal_rst_pend && cal_factor == '0));

    assert_pend_aborts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cal_rst_pend |=> (!cal_busy && !cal_done));

    assert_off_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_en && !cal_busy) |=> !cal_busy);

    assert_poweroff_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_en |=> (cal_factor == '0 && !cal_busy));
endmodule

bind adc_cal_seq adc_cal_seq_chk #(.FW(FW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_en      (conv_en),
    .cal_start_wr (cal_start_wr),
    .cal_rst_wr   (cal_rst_wr),
    .cal_busy     (cal_busy),
    .cal_rst_pend (cal_rst_pend),
    .cal_done     (cal_done),
    .cal_factor   (cal_factor),
    .conv_go      (conv_go)
);

// File: tb/adc_cal_seq_tb.sv
`timescale 1ns/1ps
module adc_cal_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_en = 1'b0, cal_start_wr = 1'b0, cal_rst_wr = 1'b0;
    logic        conv_req = 1'b0, raw_valid = 1'b0;
    logic [11:0] raw_data = '0;
    logic        cmp_in;
    logic        cal_busy, cal_rst_pend, cal_done, conv_go, corr_valid;
    logic [6:0]  trim_code, cal_factor;
    logic [11:0] corr_data;
    int          target = 0;
    int          checks = 0, errors = 0;

    always #4 clk = ~clk;

    // offset stub: comparator says the trial is too high when trim-64 > target
    assign cmp_in = (int'(trim_code) - 64) > target;

    adc_cal_seq u_dut (
        .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .cal_start_wr(cal_start_wr),
        .cal_rst_wr(cal_rst_wr), .cmp_in(cmp_in), .conv_req(conv_req),
        .raw_valid(raw_valid), .raw_data(raw_data), .cal_busy(cal_busy),
        .cal_rst_pend(cal_rst_pend), .cal_done(cal_done), .trim_code(trim_code),
        .cal_factor(cal_factor), .conv_go(conv_go), .corr_valid(corr_valid),
        .corr_data(corr_data)
    );

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int fac();
        return int'($signed(cal_factor));
    endfunction

    task automatic power_up();
        conv_en = 1'b1;
        repeat (15) tick();
    endtask

    task automatic run_cal(int t, int exp_f);
        int n;
        target = t;
        cal_start_wr = 1'b1; tick(); cal_start_wr = 1'b0;
        check("R1 busy set", int'(cal_busy), 1);
        check("R2 first trial MSB", int'(trim_code), 64);
        conv_req = 1'b1;
        n = 0;
        while (cal_busy && n < 20) begin
            #1;
            check("R4 go blocked", int'(conv_go), 0);
            tick(); n++;
        end
        check("R1 busy length", n, 8);
        check("R3 done pulse", int'(cal_done), 1);
        check("R2 factor", fac(), exp_f);
        check("R4 go after cal", int'(conv_go), 1);
        conv_req = 1'b0;
        tick();
        check("R3 done one cycle", int'(cal_done), 0);
    endtask

    task automatic t_reset();
        check("R11 busy", int'(cal_busy), 0);
        check("R11 pend", int'(cal_rst_pend), 0);
        check("R11 done", int'(cal_done), 0);
        check("R11 factor", int'(cal_factor), 0);
        check("R11 corr_valid", int'(corr_valid), 0);
    endtask

    task automatic t_disabled();
        cal_start_wr = 1'b1; tick(); cal_start_wr = 1'b0;
        check("R5 start ignored off", int'(cal_busy), 0);
        tick();
        check("R5 still idle", int'(cal_busy), 0);
    endtask

    task automatic t_settle();
        conv_en = 1'b1;
        repeat (13) tick();
        cal_start_wr = 1'b1; tick(); cal_start_wr = 1'b0;
        check("R6 early start ignored", int'(cal_busy), 0);
        run_cal(20, 20);
    endtask

    task automatic t_correct();
        raw_valid = 1'b1; raw_data = 12'd1000; tick();
        check("R9 valid", int'(corr_valid), 1);
        check("R9 mid", int'(corr_data), 980);
        raw_data = 12'd10; tick();
        check("R9 low sat", int'(corr_data), 0);
        raw_valid = 1'b0; tick();
        check("R9 valid drop", int'(corr_valid), 0);
    endtask

    task automatic t_high_sat();
        run_cal(-10, -10);
        raw_valid = 1'b1; raw_data = 12'd4090; tick();
        check("R9 high sat", int'(corr_data), 4095);
        raw_valid = 1'b0;
    endtask

    task automatic t_rst_bit();
        cal_rst_wr = 1'b1; tick(); cal_rst_wr = 1'b0;
        check("R7 pend set", int'(cal_rst_pend), 1);
        conv_req = 1'b1; #1;
        check("R4 go blocked by pend", int'(conv_go), 0);
        tick(); conv_req = 1'b0;
        check("R7 pend cleared", int'(cal_rst_pend), 0);
        check("R7 factor cleared", int'(cal_factor), 0);
    endtask

    task automatic t_abort();
        target = 30;
        cal_start_wr = 1'b1; tick(); cal_start_wr = 1'b0;
        tick(); tick();
        cal_rst_wr = 1'b1; tick(); cal_rst_wr = 1'b0;
        check("R8 busy during pend", int'(cal_busy), 1);
        tick();
        check("R8 aborted busy", int'(cal_busy), 0);
        check("R8 no done", int'(cal_done), 0);
        check("R8 factor zero", int'(cal_factor), 0);
    endtask

    task automatic t_collide_load();
        target = 40;
        cal_start_wr = 1'b1; tick(); cal_start_wr = 1'b0;
        repeat (6) tick();
        cal_rst_wr = 1'b1; tick(); cal_rst_wr = 1'b0;
        check("R8 pend in load", int'(cal_rst_pend), 1);
        tick();
        check("R8 load lost done", int'(cal_done), 0);
        check("R8 load lost busy", int'(cal_busy), 0);
        check("R8 load lost factor", int'(cal_factor), 0);
    endtask

    task automatic t_collide_start();
        cal_start_wr = 1'b1; cal_rst_wr = 1'b1; tick();
        cal_start_wr = 1'b0; cal_rst_wr = 1'b0;
        check("R8 start refused", int'(cal_busy), 0);
        check("R8 reset taken", int'(cal_rst_pend), 1);
        tick();
    endtask

    task automatic t_poweroff();
        run_cal(17, 17);
        conv_en = 1'b0; tick();
        check("R10 factor cleared", int'(cal_factor), 0);
        conv_en = 1'b1;
        cal_start_wr = 1'b1; tick(); cal_start_wr = 1'b0;
        check("R10 settle restarted", int'(cal_busy), 0);
        target = 5;
        cal_start_wr = 1'b1; tick(); cal_start_wr = 1'b0;
        tick();
        conv_en = 1'b0; tick();
        check("R10 run stopped", int'(cal_busy), 0);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_disabled();
        t_settle();
        t_correct();
        t_high_sat();
        run_cal(-64, -64);
        run_cal(63, 63);
        run_cal(100, 63);
        run_cal(-100, -64);
        t_rst_bit();
        t_abort();
        t_collide_load();
        t_collide_start();
        t_poweroff();
        power_up();
        run_cal(-5, -5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule